// File: doc/BRIEF.md
# SPI Flash Serial Read Engine

This block runs a single-lane read transaction on an SPI NOR flash and returns the bytes it receives. A one-cycle start request carries a 24-bit start address and a byte count. The engine lowers chip select and sends the read command and then the address, both most significant bit first, on MOSI. It then clocks in the requested number of bytes from MISO and presents each one on a byte bus with a one-cycle valid strobe. When the last byte is in, it releases chip select and raises a one-cycle done pulse.

The serial clock is the system clock divided down. Each half period of the serial clock lasts `SCK_HALF` system clocks. The flash latches MOSI on rising serial-clock edges and updates MISO on falling edges. The engine therefore changes MOSI only on falling edges and samples MISO only on rising edges. The first data bit is driven by the falling edge that closes the last address bit. The engine counts edges exactly, so it neither reads the floating MISO line before the data phase nor reads the level the flash holds after the last byte. During the data phase MOSI carries an alternating pattern, so no stray command can reach the flash.

Top module: `spi_flash_reader`

## Requirements
- R1: Out of reset, spi_cs_no is 1, spi_sclk_o is 0, and valid_o and done_o are 0.
- R2: spi_sclk_o is low whenever spi_cs_no is high. After an accepted start, spi_cs_no is low for at least one system clock before the first rising edge of spi_sclk_o.
- R3: The first 8 bits that MOSI holds at rising serial-clock edges are the read command 03h, MSB first.
- R4: The next 24 bits at rising edges are the address presented with the start request, MSB first. The address is latched when the start is accepted.
- R5: MISO is sampled only at rising edges 33 to 32+8·N of the transaction, where N is the byte count. Each group of 8 samples forms one byte, MSB first. MISO is ignored at all other times.
- R6: Each received byte appears on data_o together with a one-cycle pulse on valid_o. A transaction yields exactly N such pulses, in address order.
- R7: From the falling edge that ends the 32nd bit onward, MOSI alternates 0,1,0,1,… Each data byte's bits, as seen at rising edges, therefore read 55h.
- R8: After the last data bit is sampled, the next falling serial-clock edge ends the transaction. On that edge spi_cs_no goes high, spi_sclk_o is low, and done_o pulses for exactly one cycle. A MISO level held after the last byte never produces an extra byte.
- R9: A start request that arrives while a transaction is in progress is ignored. It changes neither the running transaction nor what follows it.
- R10: A start request with a byte count of 0 is ignored. Chip select does not fall and no done pulse appears.
- R11: MOSI never changes in the system clock in which spi_sclk_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | ADDR_W (24) | Start address, sampled with start_i |
| len_i | input | LEN_W | Number of bytes to read, sampled with start_i |
| data_o | output | 8 | Most recently received byte |
| valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | One-cycle pulse when the transaction ends |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench's flash model drives random values on MISO whenever it is not presenting data. An engine that started sampling one edge early would pick up that junk, or would be off by one bit in every byte. After the last byte the model keeps driving the next byte's first bit on its final falling edge. A design that missed the end count would deliver a surplus byte or keep chip select low. The bench also aims at address wrap at the top of the address space, single-byte reads, a zero byte count, and a second start fired in the middle of a transaction. A design that did not latch its inputs would send the wrong header, and one that did not gate starts would run twice.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] RD_CMD = 8'h03;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [0:0] {
    ST_IDLE,
    ST_XFER
  } rd_state_e;
endpackage

// File: rtl/spi_rd_sck.sv
module spi_rd_sck #(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CNT_LAST);
  assign rise_o = tick & ~sck_o;
  assign fall_o = tick & sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int unsigned HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             shift_i,
  output logic             mosi_o
);
  logic [HDR_W-1:0] sr_q;
  logic             fill_q;

  // Fill bits enter at the bottom; with an even header length they
  // surface as 0,1,0,1 starting at the fall that ends the header.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      fill_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= hdr_i;
      fill_q <= 1'b0;
    end else if (shift_i) begin
      sr_q   <= {sr_q[HDR_W-2:0], fill_q};
      fill_q <= ~fill_q;
    end
  end

  assign mosi_o = sr_q[HDR_W-1];
endmodule

// File: rtl/spi_rd_rx.sv
module spi_rd_rx
  import spi_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic              miso_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic [BW-1:0]     bit_q;
  logic [BYTE_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      sr_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        bit_q <= '0;
      end else if (smp_i) begin
        sr_q  <= {sr_q[BYTE_W-3:0], miso_i};
        bit_q <= bit_q + BW'(1);
        if (bit_q == BIT_LAST) begin
          byte_o  <= {sr_q, miso_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned ADDR_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              spi_cs_no,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int unsigned HDR_W  = CMD_W + ADDR_W;
  localparam int unsigned RISE_W = LEN_W + $clog2(BYTE_W) + $clog2(HDR_W) + 1;
  localparam logic [RISE_W-1:0] HDR_RISES = RISE_W'(HDR_W);

  rd_state_e         state_q;
  logic [LEN_W-1:0]  len_q;
  logic [RISE_W-1:0] rise_cnt_q;
  logic [RISE_W-1:0] rise_total;
  logic              accept, run, rise, fall, in_data, last_fall;

  assign accept     = (state_q == ST_IDLE) && start_i && (len_i != '0);
  assign run        = (state_q == ST_XFER);
  assign rise_total = HDR_RISES + (RISE_W'(len_q) << $clog2(BYTE_W));
  assign in_data    = (rise_cnt_q >= HDR_RISES);
  assign last_fall  = fall && (rise_cnt_q == rise_total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      len_q      <= '0;
      rise_cnt_q <= '0;
      spi_cs_no  <= 1'b1;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_XFER;
            len_q      <= len_i;
            rise_cnt_q <= '0;
            spi_cs_no  <= 1'b0;
          end
        end
        ST_XFER: begin
          if (rise) rise_cnt_q <= rise_cnt_q + RISE_W'(1);
          if (last_fall) begin
            state_q   <= ST_IDLE;
            spi_cs_no <= 1'b1;
            done_o    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_rd_sck #(
    .SCK_HALF(SCK_HALF)
  ) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sck_o (spi_sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_rd_tx #(
    .HDR_W(HDR_W)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .hdr_i  ({RD_CMD, addr_i}),
    .shift_i(fall),
    .mosi_o (spi_mosi_o)
  );

  spi_rd_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .smp_i  (rise && in_data),
    .miso_i (spi_miso_i),
    .byte_o (data_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic sclk_i,
  input logic mosi_i,
  input logic valid_i,
  input logic done_i
);
  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sclk_i);

  p_cs_lead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> !$past(cs_n_i));

  p_mosi_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> $stable(mosi_i));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_valid_in_txn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !cs_n_i);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cs_n_i && !sclk_i && $fell(sclk_i)));
endmodule

bind spi_flash_reader spi_flash_reader_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_i (spi_cs_no),
  .sclk_i (spi_sclk_o),
  .mosi_i (spi_mosi_o),
  .valid_i(valid_o),
  .done_i (done_o)
);

// File: tb/spi_flash_reader_tb_top.sv
module spi_flash_reader_tb_top;
  localparam int unsigned LEN_W = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0]  data_o;
  logic        valid_o, done_o, spi_cs_no, spi_sclk_o, spi_mosi_o;
  logic        spi_miso_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  spi_flash_reader #(.SCK_HALF(2), .LEN_W(LEN_W), .ADDR_W(24)) dut_i (.*);

  function automatic logic [7:0] mem_b(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[23:20], a[3:0]} ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model
  int rise_n = 0, fall_n = 0, pat_bad = 0, cs_falls = 0;
  logic [7:0]  rx_cmd, pat;
  logic [23:0] rx_addr;

  always @(negedge spi_cs_no) begin
    rise_n = 0; fall_n = 0; cs_falls++;
  end
  always @(posedge spi_cs_no) spi_miso_i = 1'($urandom);

  always @(posedge spi_sclk_o) if (!spi_cs_no) begin
    rise_n++;
    if (rise_n <= 8) rx_cmd = {rx_cmd[6:0], spi_mosi_o};
    else if (rise_n <= 32) rx_addr = {rx_addr[22:0], spi_mosi_o};
    else begin
      pat = {pat[6:0], spi_mosi_o};
      if (((rise_n - 32) % 8) == 0 && pat != 8'h55) pat_bad++;
    end
  end

  always @(negedge spi_sclk_o) if (!spi_cs_no) begin
    fall_n++;
    if (fall_n >= 32) begin
      logic [7:0] b;
      b = mem_b(rx_addr + 24'((fall_n - 32) / 8));
      spi_miso_i = b[7 - ((fall_n - 32) % 8)];
    end else begin
      spi_miso_i = 1'($urandom);
    end
  end

  // output monitors
  logic [7:0] got[$];
  int done_cnt = 0, idle_bad = 0, lead = 0;
  always @(negedge clk_i) if (rst_ni) begin
    if (valid_o) got.push_back(data_o);
    if (done_o) done_cnt++;
    if (spi_cs_no && spi_sclk_o) idle_bad++;
    if (!spi_cs_no && rise_n == 0 && !spi_sclk_o) lead++;
  end

  task automatic run_txn(input logic [23:0] a, input int n, input bit poke);
    int base_done, base_cs;
    got.delete();
    base_done = done_cnt; base_cs = cs_falls; lead = 0; pat_bad = 0;
    @(negedge clk_i); start_i = 1'b1; addr_i = a; len_i = LEN_W'(n);
    @(negedge clk_i); start_i = 1'b0; addr_i = 24'($urandom); len_i = LEN_W'($urandom);
    if (poke) begin
      repeat (40) @(negedge clk_i);
      start_i = 1'b1; len_i = LEN_W'(3);
      @(negedge clk_i); start_i = 1'b0;
    end
    while (done_cnt == base_done) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
    check("R3 command", 32'(rx_cmd), 32'h03);
    check("R4 address", 32'(rx_addr), 32'(a));
    check("R2 cs lead cycles>=1", 32'(lead >= 1), 32'd1);
    check("R6 byte count", 32'(got.size()), 32'(n));
    for (int k = 0; k < n && k < got.size(); k++)
      check("R5 data byte", 32'(got[k]), 32'(mem_b(a + 24'(k))));
    check("R7 mosi pattern bytes", 32'(pat_bad), 32'd0);
    check("R8 single done", 32'(done_cnt - base_done), 32'd1);
    check("R8 cs released", 32'(spi_cs_no), 32'd1);
    if (poke) check("R9 no second cs fall", 32'(cs_falls - base_cs), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20231004));
    repeat (4) @(negedge clk_i);
    check("R1 cs_n", 32'(spi_cs_no), 32'd1);
    check("R1 sclk", 32'(spi_sclk_o), 32'd0);
    check("R1 valid", 32'(valid_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    run_txn(24'h000060, 5, 1'b0);
    run_txn(24'hFFFFFE, 4, 1'b0);   // address wrap
    run_txn(24'h123456, 1, 1'b0);
    run_txn(24'h0ABCDE, 3, 1'b1);   // R9 start during transaction
    for (int i = 0; i < 10; i++)
      run_txn(24'($urandom), 1 + int'($urandom % 7), 1'b0);

    begin : zero_len
      int bd, bc;
      bd = done_cnt; bc = cs_falls; got.delete();
      @(negedge clk_i); start_i = 1'b1; len_i = '0; addr_i = 24'h55AA00;
      @(negedge clk_i); start_i = 1'b0;
      repeat (200) @(negedge clk_i);
      check("R10 no cs fall", 32'(cs_falls - bc), 32'd0);
      check("R10 no done", 32'(done_cnt - bd), 32'd0);
      check("R10 no bytes", 32'(got.size()), 32'd0);
    end
    check("R2 sclk low while cs high", 32'(idle_bad), 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule